// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one pulse-width-modulated output channel with a small register bank on a simple synchronous host bus. A mode register sets the counting rate, the alignment (edge or center), the idle level of the output and the target of the buffered update. Duty and period registers shape the waveform, a read-only counter register shows the running count, and an update register holds one buffered value. That value is written into either the period or the duty at the next period boundary, so software can change a running waveform without glitches.

The counting tick comes from the master clock through a power-of-two prescaler, or from one of two externally generated single-cycle tick inputs. At every period boundary the channel pulses an interrupt for one cycle, so software can time its next buffered write. While the enable input is low the counter and prescaler are cleared and the output rests at its idle level. Direct writes to mode, duty and period are accepted only then.

Top module: `pwm_chan`

## Requirements
- R1: After reset every register reads zero, `pwm_o` is low and `irq_o` is low.
- R2: Reads while `sel_i` is high and `wr_i` is low return, by byte address, mode at 0x00, duty at 0x04, period at 0x08, counter at 0x0C and the update buffer at 0x10. Any other address returns zero, and `rdata_o` is zero while `sel_i` is low. In the mode register, bits [3:0] are the rate code, bit 8 selects center alignment, bit 9 selects an idle-high output and bit 10 makes the update buffer target the period (clear: the duty). All other mode bits read zero.
- R3: While `en_i` is high, writes to mode, duty and period have no effect. The update register can be written at any time.
- R4: A value written to duty is stored as the smaller of that value and the current period.
- R5: Rate codes 0 to 10 give one tick every 2^code master-clock cycles, the first tick coming 2^code cycles after enable rises. Code 0xB takes ticks from `clka_tick_i` and code 0xC from `clkb_tick_i`. Codes 0xD to 0xF tick every cycle.
- R6: In edge alignment, each tick advances the counter from 0 to period-1 and then wraps to 0. The wrap is the period boundary. A period of 0 or 1 gives a boundary on every tick.
- R7: In center alignment, the counter counts up to the period value and then back down. The boundary is the tick that brings it from 1 to 0, so one period lasts 2×period ticks.
- R8: While enabled, the output is in its active state when the counter is below the duty value. The active state is high when mode bit 9 is clear and low when it is set.
- R9: While `en_i` is low, the output holds the idle level (mode bit 9). The counter and prescaler are cleared on every clock, so the counter reads 0.
- R10: A written update value is applied only at a period boundary, never mid-period. It replaces the period when mode bit 10 is set. Otherwise it replaces the duty, clamped to the period in force before that boundary. Each written value is applied once.
- R11: `irq_o` is high for exactly the cycle that follows each boundary tick.
- R12: An update write in the same cycle as a boundary does not take effect at that boundary. An already pending value is applied there, and the new value waits for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel run enable |
| clka_tick_i | input | 1 | External tick source A, one-cycle pulses |
| clkb_tick_i | input | 1 | External tick source B, one-cycle pulses |
| sel_i | input | 1 | Bus select |
| wr_i | input | 1 | Bus write strobe (with sel_i) |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| pwm_o | output | 1 | Waveform output |
| irq_o | output | 1 | Once-per-period interrupt pulse |

## Verification
The risky coincidence is a host write to the update register landing in the same clock as a period boundary. In that cycle, applying the pending value and loading the new one compete for the same pending flag. The bench's reference model predicts the counter, so stimulus waits until the model shows the last tick of a period and then issues the write on exactly that edge. This is done once with an older value still pending and once with none. The per-cycle comparison of the counter readback, `pwm_o` and `irq_o` then shows which period length took effect at each boundary, which separates the two valid outcomes from an early or lost update.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // byte offsets; the host decodes these
  localparam int OFS_MODE = 'h00;
  localparam int OFS_DUTY = 'h04;
  localparam int OFS_PRD  = 'h08;
  localparam int OFS_CNT  = 'h0C;
  localparam int OFS_UPD  = 'h10;

  // mode bit positions
  localparam int BIT_UPD_PRD = 10;
  localparam int BIT_IDLE_HI = 9;
  localparam int BIT_CENTER  = 8;

  localparam logic [3:0] RATE_EXT_A = 4'hB;
  localparam logic [3:0] RATE_EXT_B = 4'hC;

  typedef struct packed {
    logic       upd_prd;
    logic       idle_hi;
    logic       center;
    logic [3:0] rate;
  } mode_t;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int MAX_PRE = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [3:0] rate_i,
  input  logic       clka_i,
  input  logic       clkb_i,
  output logic       tick_o
);
  import pwm_pkg::*;

  localparam logic [3:0] MAX_PRE_C = 4'(MAX_PRE);

  logic [MAX_PRE-1:0] psc_q;
  logic [MAX_PRE-1:0] mask;
  logic               raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    psc_q <= '0;
    else if (!en_i) psc_q <= '0;
    else            psc_q <= psc_q + 1'b1;
  end

  assign mask = ~({MAX_PRE{1'b1}} << rate_i);

  always_comb begin
    if (rate_i == RATE_EXT_A)      raw = clka_i;
    else if (rate_i == RATE_EXT_B) raw = clkb_i;
    else if (rate_i <= MAX_PRE_C)  raw = ((psc_q & mask) == mask);
    else                           raw = 1'b1; // reserved codes: divide by 1
  end

  assign tick_o = en_i & raw;

  p_no_tick_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (psc_q == '0));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic             idle_hi_i,
  input  logic [CNT_W-1:0] prd_i,
  input  logic [CNT_W-1:0] dty_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             boundary_o,
  output logic             irq_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             irq_q;
  logic             wrap;
  logic [CNT_W:0]   cnt_inc;
  logic             at_top;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign at_top  = cnt_inc >= {1'b0, prd_i};

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    wrap   = 1'b0;
    if (!en_i) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (tick_i) begin
      if (!center_i) begin
        if (at_top) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end else if (!down_q) begin
        if (at_top) begin
          cnt_d  = prd_i;
          down_d = 1'b1;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end else if (cnt_q <= CNT_W'(1)) begin
        cnt_d  = '0;
        down_d = 1'b0;
        wrap   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      irq_q  <= wrap;
    end
  end

  assign cnt_o      = cnt_q;
  assign boundary_o = wrap;
  assign irq_o      = irq_q;
  assign pwm_o      = idle_hi_i ^ (en_i & (cnt_q < dty_i));

  p_edge_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !center_i && prd_i != '0) |-> (cnt_q < prd_i));

  p_center_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && center_i) |-> (cnt_q <= prd_i));

  p_cleared_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_o == '0));

  p_idle_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (pwm_o == idle_hi_i));
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 sel_i,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 boundary_i,
  output pwm_pkg::mode_t       mode_o,
  output logic [CNT_W-1:0]     prd_o,
  output logic [CNT_W-1:0]     dty_o,
  output logic [DATA_W-1:0]    rdata_o
);
  import pwm_pkg::*;

  localparam int WORD_W = ADDR_W - 2;
  localparam int PAD_W  = DATA_W - CNT_W;

  mode_t            mode_q;
  logic [CNT_W-1:0] prd_q, dty_q, upd_q;
  logic             pend_q;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  wval;
  logic wr_en, wr_mode, wr_dty, wr_prd, wr_upd, apply;
  logic [DATA_W-1:0] mode_rd;
  logic unused_bits;

  function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] v,
                                             input logic [CNT_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  assign word    = addr_i[ADDR_W-1:2];
  assign wval    = wdata_i[CNT_W-1:0];
  assign wr_en   = sel_i & wr_i;
  assign wr_mode = wr_en & ~en_i & (word == WORD_W'(OFS_MODE >> 2));
  assign wr_dty  = wr_en & ~en_i & (word == WORD_W'(OFS_DUTY >> 2));
  assign wr_prd  = wr_en & ~en_i & (word == WORD_W'(OFS_PRD  >> 2));
  assign wr_upd  = wr_en &         (word == WORD_W'(OFS_UPD  >> 2));
  assign apply   = boundary_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      prd_q  <= '0;
      dty_q  <= '0;
      upd_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_mode) begin
        mode_q.upd_prd <= wdata_i[BIT_UPD_PRD];
        mode_q.idle_hi <= wdata_i[BIT_IDLE_HI];
        mode_q.center  <= wdata_i[BIT_CENTER];
        mode_q.rate    <= wdata_i[3:0];
      end
      if (wr_prd)                          prd_q <= wval;
      else if (apply && mode_q.upd_prd)    prd_q <= upd_q;
      if (wr_dty)                          dty_q <= clamp(wval, prd_q);
      else if (apply && !mode_q.upd_prd)   dty_q <= clamp(upd_q, prd_q);
      if (wr_upd) upd_q <= wval;
      // a write in the boundary cycle stays pending for the next one
      if (wr_upd)          pend_q <= 1'b1;
      else if (boundary_i) pend_q <= 1'b0;
    end
  end

  always_comb begin
    mode_rd              = '0;
    mode_rd[BIT_UPD_PRD] = mode_q.upd_prd;
    mode_rd[BIT_IDLE_HI] = mode_q.idle_hi;
    mode_rd[BIT_CENTER]  = mode_q.center;
    mode_rd[3:0]         = mode_q.rate;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      if      (word == WORD_W'(OFS_MODE >> 2)) rdata_o = mode_rd;
      else if (word == WORD_W'(OFS_DUTY >> 2)) rdata_o = {{PAD_W{1'b0}}, dty_q};
      else if (word == WORD_W'(OFS_PRD  >> 2)) rdata_o = {{PAD_W{1'b0}}, prd_q};
      else if (word == WORD_W'(OFS_CNT  >> 2)) rdata_o = {{PAD_W{1'b0}}, cnt_i};
      else if (word == WORD_W'(OFS_UPD  >> 2)) rdata_o = {{PAD_W{1'b0}}, upd_q};
    end
  end

  assign mode_o = mode_q;
  assign prd_o  = prd_q;
  assign dty_o  = dty_q;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:CNT_W]};

  p_mode_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(mode_q));

  p_prd_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !boundary_i) |=> $stable(prd_q));

  p_dty_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !boundary_i) |=> $stable(dty_q));

  p_dty_clamped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dty |=> (dty_q <= prd_q));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 20,
  parameter int MAX_PRE = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clka_tick_i,
  input  logic              clkb_tick_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o,
  output logic              irq_o
);
  import pwm_pkg::*;

  mode_t            mode;
  logic [CNT_W-1:0] prd, dty, cnt;
  logic             tick, boundary;

  pwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .sel_i      (sel_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .boundary_i (boundary),
    .mode_o     (mode),
    .prd_o      (prd),
    .dty_o      (dty),
    .rdata_o    (rdata_o)
  );

  pwm_tick_gen #(.MAX_PRE(MAX_PRE)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .rate_i (mode.rate),
    .clka_i (clka_tick_i),
    .clkb_i (clkb_tick_i),
    .tick_o (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick),
    .center_i   (mode.center),
    .idle_hi_i  (mode.idle_hi),
    .prd_i      (prd),
    .dty_i      (dty),
    .cnt_o      (cnt),
    .boundary_o (boundary),
    .irq_o      (irq_o),
    .pwm_o      (pwm_o)
  );
endmodule

// File: tb/pwm_chan_tb.sv
`timescale 1ns/1ps
module pwm_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, clka = 1'b0, clkb = 1'b0;
  logic        sel = 1'b1, wr_r = 1'b0;
  logic [4:0]  addr = 5'h0C;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm, irq;

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  pwm_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clka_tick_i(clka), .clkb_tick_i(clkb),
    .sel_i(sel), .wr_i(wr_r), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  // external tick sources: A every 3rd cycle, B every 5th
  int ca = 0, cb = 0;
  always @(negedge clk) begin
    #1;
    ca = (ca + 1) % 3;
    cb = (cb + 1) % 5;
    clka = (ca == 0);
    clkb = (cb == 0);
  end

  // ---------------- reference model ----------------
  int m_rate, m_center, m_idle, m_updprd;
  int m_dty, m_prd, m_cnt, m_dn, m_psc, m_upd, m_pend, m_irq;

  function automatic int min_i(int a, int b);
    return (a < b) ? a : b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rate = 0; m_center = 0; m_idle = 0; m_updprd = 0;
      m_dty = 0; m_prd = 0; m_cnt = 0; m_dn = 0; m_psc = 0;
      m_upd = 0; m_pend = 0; m_irq = 0;
    end else begin
      int tk, bnd, ncnt, ndn, nprd, ndty, nupd, npend, w, wd;
      bit wupd;
      tk = 0; bnd = 0; wupd = 0;
      if (en) begin
        if (m_rate == 11)      tk = clka;
        else if (m_rate == 12) tk = clkb;
        else if (m_rate > 10)  tk = 1;
        else                   tk = ((m_psc % (1 << m_rate)) == (1 << m_rate) - 1);
      end
      ncnt = m_cnt; ndn = m_dn;
      if (!en) begin ncnt = 0; ndn = 0; end
      else if (tk) begin
        if (!m_center) begin
          if (m_cnt + 1 >= m_prd) begin ncnt = 0; bnd = 1; end else ncnt = m_cnt + 1;
        end else if (!m_dn) begin
          if (m_cnt + 1 >= m_prd) begin ncnt = m_prd; ndn = 1; end else ncnt = m_cnt + 1;
        end else begin
          if (m_cnt <= 1) begin ncnt = 0; ndn = 0; bnd = 1; end else ncnt = m_cnt - 1;
        end
      end
      nprd = m_prd; ndty = m_dty; nupd = m_upd; npend = m_pend;
      w = int'(wdata & 32'hFFFFF);
      wd = int'(addr) / 4;
      if (sel && wr_r) begin
        if (wd == 0 && !en) begin
          m_updprd = wdata[10]; m_idle = wdata[9]; m_center = wdata[8];
          m_rate = int'(wdata[3:0]);
        end
        if (wd == 1 && !en) ndty = min_i(w, m_prd);
        if (wd == 2 && !en) nprd = w;
        if (wd == 4) begin nupd = w; npend = 1; wupd = 1; end
      end
      if (bnd && m_pend) begin
        if (m_updprd) nprd = m_upd; else ndty = min_i(m_upd, m_prd);
      end
      if (bnd && !wupd) npend = 0;
      m_psc = en ? (m_psc + 1) % 1024 : 0;
      m_cnt = ncnt; m_dn = ndn; m_prd = nprd; m_dty = ndty;
      m_upd = nupd; m_pend = npend; m_irq = bnd;
    end
  end

  function automatic logic [31:0] exp_rd();
    if (!sel || wr_r) return 32'h0;
    case (int'(addr) / 4)
      0: return 32'(m_updprd << 10 | m_idle << 9 | m_center << 8 | m_rate);
      1: return 32'(m_dty);
      2: return 32'(m_prd);
      3: return 32'(m_cnt);
      4: return 32'(m_upd);
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      logic ep;
      ep = logic'(m_idle) ^ (en && (m_cnt < m_dty));
      n_cmp += 3;
      if (pwm !== ep) begin
        n_bad++; $display("FAIL %s pwm_o got %0b exp %0b t=%0t", tag, pwm, ep, $time);
      end
      if (irq !== logic'(m_irq)) begin
        n_bad++; $display("FAIL %s irq_o got %0b exp %0b t=%0t", tag, irq, m_irq, $time);
      end
      if (rdata !== exp_rd()) begin
        n_bad++; $display("FAIL %s rdata_o got %0h exp %0h t=%0t", tag, rdata, exp_rd(), $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic wr_now(int a, int d);
    #1; sel = 1; wr_r = 1; addr = 5'(a); wdata = 32'(d);
    @(negedge clk); #1; wr_r = 0; addr = 5'h0C;
  endtask

  task automatic wreg(int a, int d); @(negedge clk); wr_now(a, d); endtask

  task automatic rreg(int a);
    @(negedge clk); #1; wr_r = 0; addr = 5'(a);
    @(negedge clk); #1; addr = 5'h0C;
  endtask

  task automatic set_en(logic b); @(negedge clk); #1; en = b; endtask

  task automatic read_all();
    rreg('h00); rreg('h04); rreg('h08); rreg('h0C); rreg('h10);
  endtask

  task automatic wait_last_tick();
    do @(negedge clk); while (!(en && m_cnt == m_prd - 1));
  endtask

  initial begin
    fork
      begin
        idle(3); #1; rst_n = 1'b1;
        tag = "R1"; idle(2); read_all();

        tag = "R2";
        wreg('h08, 10); wreg('h04, 4); wreg('h00, 'h0000_F8F0); read_all();
        rreg('h14); rreg('h1C);
        @(negedge clk); #1; sel = 0; addr = 5'h04; idle(2); #1; sel = 1; addr = 5'h0C;
        wreg('h00, 0);

        tag = "R4"; wreg('h04, 15); rreg('h04); wreg('h04, 4); rreg('h04);

        tag = "R6"; set_en(1); idle(45);
        tag = "R3"; wreg('h00, 'h700); wreg('h04, 1); wreg('h08, 3); read_all(); idle(5);

        tag = "R10"; wreg('h10, 7); rreg('h04); idle(30);
        tag = "R9"; set_en(0); idle(6); read_all();
        wreg('h00, 'h401);
        tag = "R11"; set_en(1); wreg('h10, 6); idle(40);
        tag = "R6"; set_en(0); wreg('h08, 1); wreg('h00, 'h0); wreg('h04, 1);
        set_en(1); idle(8); set_en(0); wreg('h08, 0); set_en(1); idle(6);

        tag = "R12"; set_en(0); wreg('h00, 'h400); wreg('h08, 8); wreg('h04, 3); set_en(1);
        do @(negedge clk); while (m_cnt != 1);
        wr_now('h10, 12);
        wait_last_tick(); wr_now('h10, 6); idle(40);
        wait_last_tick(); wr_now('h10, 9); idle(40);

        tag = "R7"; set_en(0); wreg('h00, 'h300); wreg('h08, 5); wreg('h04, 2);
        set_en(1); idle(40); wreg('h10, 4); idle(30);
        tag = "R8"; set_en(0); wreg('h08, 1); wreg('h00, 'h300); set_en(1); idle(12);
        tag = "R8"; set_en(0); wreg('h00, 'h200); wreg('h08, 6); wreg('h04, 3); set_en(1); idle(30);

        tag = "R5";
        set_en(0); wreg('h00, 'h003); set_en(1); idle(150);
        set_en(0); wreg('h00, 'h00B); set_en(1); idle(80);
        set_en(0); wreg('h00, 'h00C); set_en(1); idle(100);
        set_en(0); wreg('h00, 'h00E); set_en(1); idle(30);
        set_en(0); wreg('h00, 'h00D); set_en(1); idle(20);
        set_en(0); wreg('h08, 2); wreg('h04, 1); wreg('h00, 'h00A); set_en(1); idle(4200);
        tag = "R9"; set_en(0); idle(4); read_all();
      end
      begin
        #(200000 * 5);
        n_bad++; $display("FAIL watchdog: run did not finish, got hang exp completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule